// File: doc/BRIEF.md
# Boundary Scan Test Access Logic

This block is the test access port of one chip. A four-wire serial test interface with its own test clock and an optional active-low asynchronous reset steers a sixteen-state controller with the mode-select line. Depending on that controller, a four-bit instruction register or one data register is connected between the serial input and the serial output. The data registers are a one-bit pass-through stage, a 32-bit identification register, a 32-bit user code register and a boundary register of three cells per pin. The three cells of a pin are input, output data and output enable.

The boundary register sits between the core and the package pins. A central decoder maps each instruction to two independent choices. The first is the data register on the serial path. The second is the source of the pins and of the core inputs: the core, the boundary update latches, or forced high impedance. Board test software uses this block to read device identity, snapshot live pins, drive interconnect patterns, hold pins at a safe state while bypassing the chip, or float every output. The serial interface is a plain clocked protocol with no back-pressure, so the edge of the block has no valid/ready handshake.

Top module: `tap_access_port`

## Requirements
- R1: The controller follows the standard sixteen-state sequence steered by `mode_sel` on rising `test_clk`. Five rising edges with `mode_sel` high reach the reset state from any state, and that state loads the identification instruction (opcode 4'b0010) into the instruction register.
- R2: In Capture-IR the instruction shift register loads 4'b0101, which is shifted out least significant bit first. A newly shifted opcode acts on the pins and on the serial path only after Update-IR.
- R3: Opcode 4'b1111 and every unassigned opcode (4'b1000 to 4'b1110) select the one-bit pass-through stage. That stage captures 0 in Capture-DR, so the serial output shows 0 and then the serial input delayed by one shift.
- R4: Opcode 4'b0010 selects the 32-bit identification register. It captures the parameter `IDENT_VAL`, whose least significant bit is 1, and shifts it out least significant bit first.
- R5: Opcode 4'b0011 selects the 32-bit user code register. It captures the parameter `USER_VAL` and shifts it out least significant bit first.
- R6: Opcode 4'b0001 (snapshot/preload) selects the boundary register. In Capture-DR that register loads {core_oe, core_out, pin_in}, with cell index 0 at `pin_in[0]` nearest the serial output. Pins and core inputs stay under core control, and Update-DR copies the shifted pattern into the update latches.
- R7: Opcode 4'b0000 (external drive) drives `pin_out` from update latch bits [2N-1:N] and `pin_oe` from update latch bits [3N-1:2N].
- R8: Opcode 4'b0100 (hold) drives the pins from the update latches in the same way as R7. It selects the pass-through stage, and Update-DR leaves the latches unchanged.
- R9: Opcode 4'b0111 (float) forces every `pin_oe` bit to 0 and selects the pass-through stage.
- R10: Opcode 4'b0110 (internal drive) selects the boundary register, drives `core_in` from update latch bits [N-1:0] and drives the pins from the latches as in R7.
- R11: `ser_out` and `ser_out_en` change only on the falling edge of `test_clk`. `ser_out_en` is 1 only while the controller is in Shift-IR or Shift-DR.
- R12: A low `test_rst_n` immediately puts the controller in its reset state, the instruction register at 4'b0010, `ser_out_en` at 0 and the pins under core control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock, independent of the functional clock |
| test_rst_n | input | 1 | Asynchronous active-low test reset |
| mode_sel | input | 1 | Controller steering input, sampled on rising edge |
| ser_in | input | 1 | Serial instruction and data input, sampled on rising edge |
| ser_out | output | 1 | Serial output, updated on falling edge |
| ser_out_en | output | 1 | Serial output enable, high only in shift states |
| core_out | input | NPINS | Output data from the core logic |
| core_oe | input | NPINS | Output enables from the core logic |
| core_in | output | NPINS | Input values presented to the core logic |
| pin_in | input | NPINS | Values received at the pins |
| pin_out | output | NPINS | Data driven toward the pins |
| pin_oe | output | NPINS | Output enables toward the pins, 1 drives |

## Verification
The bench aims at the split between the serial path and the pin source. A decoder that tied the two together would shift twelve boundary bits under hold or float instead of one, or would let the hold scan overwrite the latches and move the pins. The bench checks the pins while the controller rests in Exit1-IR after a new opcode has been shifted. A design that acted on the opcode before Update-IR would change the pins there. The bench also escapes from the middle of a data shift with five mode-select highs. It then reads the unassigned opcode 4'b1010 as a one-stage pass-through; a decoder without a default would leave the serial path undefined or pick a real register.

// File: rtl/tapx_pkg.sv
package tapx_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXT   = 4'b0000;
  localparam logic [IR_W-1:0] OP_SNAP  = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDENT = 4'b0010;
  localparam logic [IR_W-1:0] OP_USER  = 4'b0011;
  localparam logic [IR_W-1:0] OP_HOLD  = 4'b0100;
  localparam logic [IR_W-1:0] OP_INT   = 4'b0110;
  localparam logic [IR_W-1:0] OP_FLOAT = 4'b0111;
  localparam logic [IR_W-1:0] OP_PASS  = 4'b1111;

  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0101;

  typedef enum logic [1:0] {
    PATH_PASS, PATH_IDENT, PATH_USER, PATH_BOUND
  } dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     pins_from_bsr;
    logic     pins_float;
    logic     core_from_bsr;
  } insn_ctl_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tapx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sel,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_RESET:  nxt = mode_sel ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = mode_sel ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = mode_sel ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = mode_sel ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = mode_sel ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = mode_sel ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = mode_sel ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = mode_sel ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = mode_sel ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = mode_sel ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = mode_sel ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = mode_sel ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = mode_sel ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = mode_sel ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = mode_sel ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = mode_sel ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tapx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            ser_in,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_q,
  output insn_ctl_t       ctl
);

  // shift stage and active instruction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr <= IR_CAPTURE;
      ir_q  <= OP_IDENT;
    end else begin
      case (state)
        ST_RESET:  ir_q  <= OP_IDENT;
        ST_CAP_IR: ir_sr <= IR_CAPTURE;
        ST_SHF_IR: ir_sr <= {ser_in, ir_sr[IR_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sr;
        default: ;
      endcase
    end
  end

  // serial path and pin source are chosen independently
  always_comb begin
    ctl = '{path: PATH_PASS, pins_from_bsr: 1'b0, pins_float: 1'b0, core_from_bsr: 1'b0};
    case (ir_q)
      OP_EXT:   begin ctl.path = PATH_BOUND; ctl.pins_from_bsr = 1'b1; end
      OP_SNAP:  ctl.path = PATH_BOUND;
      OP_IDENT: ctl.path = PATH_IDENT;
      OP_USER:  ctl.path = PATH_USER;
      OP_HOLD:  ctl.pins_from_bsr = 1'b1;
      OP_FLOAT: ctl.pins_float = 1'b1;
      OP_INT: begin
        ctl.path          = PATH_BOUND;
        ctl.pins_from_bsr = 1'b1;
        ctl.core_from_bsr = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tap_dreg.sv
module tap_dreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         shf_en,
  input  logic         ser_in,
  input  logic [W-1:0] cap_val,
  output logic         lsb
);

  logic [W-1:0] sr;

  generate
    if (W == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sr <= '0;
        else if (cap_en) sr <= cap_val;
        else if (shf_en) sr <= ser_in;
      end
    end else begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sr <= '0;
        else if (cap_en) sr <= cap_val;
        else if (shf_en) sr <= {ser_in, sr[W-1:1]};
      end
    end
  endgenerate

  assign lsb = sr[0];

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
  import tapx_pkg::*;
#(
  parameter int NPINS = 4,
  localparam int LEN = 3 * NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  logic             sel,
  input  logic             ser_in,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic             lsb,
  output logic [LEN-1:0]   upd
);

  logic [LEN-1:0] sr;
  logic [LEN-1:0] cap_vec;

  // cell layout: inputs, then output data, then output enables
  for (genvar p = 0; p < NPINS; p++) begin : g_cell
    assign cap_vec[p]           = pin_in[p];
    assign cap_vec[NPINS + p]   = core_out[p];
    assign cap_vec[2*NPINS + p] = core_oe[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      upd <= '0;
    end else if (sel) begin
      case (state)
        ST_CAP_DR: sr  <= cap_vec;
        ST_SHF_DR: sr  <= {ser_in, sr[LEN-1:1]};
        ST_UPD_DR: upd <= sr;
        default: ;
      endcase
    end
  end

  assign lsb = sr[0];

endmodule

// File: rtl/tap_access_port.sv
module tap_access_port
  import tapx_pkg::*;
#(
  parameter int          NPINS     = 4,
  parameter logic [31:0] IDENT_VAL = 32'h1A5C_E0B3,
  parameter logic [31:0] USER_VAL  = 32'h0C0F_FEE5
) (
  input  logic             test_clk,
  input  logic             test_rst_n,
  input  logic             mode_sel,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_out_en,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] core_in,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);

  localparam int LEN = 3 * NPINS;

  tap_state_e      st;
  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;
  insn_ctl_t       ctl;
  logic            pass_lsb, ident_lsb, user_lsb, bnd_lsb;
  logic [LEN-1:0]  upd;
  logic            cap_dr, shf_dr, tdo_d;

  tap_fsm u_fsm (
    .clk(test_clk), .rst_n(test_rst_n), .mode_sel(mode_sel), .state(st)
  );

  tap_ir u_ir (
    .clk(test_clk), .rst_n(test_rst_n), .state(st), .ser_in(ser_in),
    .ir_sr(ir_sr), .ir_q(ir_q), .ctl(ctl)
  );

  assign cap_dr = (st == ST_CAP_DR);
  assign shf_dr = (st == ST_SHF_DR);

  tap_dreg #(.W(1)) u_pass (
    .clk(test_clk), .rst_n(test_rst_n),
    .cap_en(cap_dr && ctl.path == PATH_PASS),
    .shf_en(shf_dr && ctl.path == PATH_PASS),
    .ser_in(ser_in), .cap_val(1'b0), .lsb(pass_lsb)
  );

  tap_dreg #(.W(32)) u_ident (
    .clk(test_clk), .rst_n(test_rst_n),
    .cap_en(cap_dr && ctl.path == PATH_IDENT),
    .shf_en(shf_dr && ctl.path == PATH_IDENT),
    .ser_in(ser_in), .cap_val(IDENT_VAL), .lsb(ident_lsb)
  );

  tap_dreg #(.W(32)) u_user (
    .clk(test_clk), .rst_n(test_rst_n),
    .cap_en(cap_dr && ctl.path == PATH_USER),
    .shf_en(shf_dr && ctl.path == PATH_USER),
    .ser_in(ser_in), .cap_val(USER_VAL), .lsb(user_lsb)
  );

  tap_bsr #(.NPINS(NPINS)) u_bsr (
    .clk(test_clk), .rst_n(test_rst_n), .state(st),
    .sel(ctl.path == PATH_BOUND), .ser_in(ser_in),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .lsb(bnd_lsb), .upd(upd)
  );

  always_comb begin
    if (st == ST_SHF_IR) tdo_d = ir_sr[0];
    else begin
      unique case (ctl.path)
        PATH_IDENT: tdo_d = ident_lsb;
        PATH_USER:  tdo_d = user_lsb;
        PATH_BOUND: tdo_d = bnd_lsb;
        default:    tdo_d = pass_lsb;
      endcase
    end
  end

  // serial output launched on the falling edge
  always_ff @(negedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) begin
      ser_out    <= 1'b0;
      ser_out_en <= 1'b0;
    end else begin
      ser_out    <= tdo_d;
      ser_out_en <= (st == ST_SHF_IR) || (st == ST_SHF_DR);
    end
  end

  always_comb begin
    pin_out = ctl.pins_from_bsr ? upd[2*NPINS-1:NPINS] : core_out;
    if (ctl.pins_float)         pin_oe = '0;
    else if (ctl.pins_from_bsr) pin_oe = upd[3*NPINS-1:2*NPINS];
    else                        pin_oe = core_oe;
    core_in = ctl.core_from_bsr ? upd[NPINS-1:0] : pin_in;
  end

endmodule

// File: rtl/tap_access_chk.sv
module tap_access_chk
  import tapx_pkg::*;
#(
  parameter int NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_sel,
  input tap_state_e       state,
  input logic [IR_W-1:0]  ir_sr,
  input logic [IR_W-1:0]  ir_q,
  input logic [NPINS-1:0] pin_oe,
  input logic             ser_out_en
);

  // R1
  five_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && $past(mode_sel) && $past(mode_sel, 2) && $past(mode_sel, 3)
     && $past(mode_sel, 4)) |=> state == ST_RESET);

  // R1
  reset_insn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RESET |=> ir_q == OP_IDENT);

  // R2
  ir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_CAP_IR |=> ir_sr[1:0] == 2'b01);

  // R2
  ir_update_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ir_q) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET));

  // R9
  float_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_q == OP_FLOAT |-> pin_oe == '0);

  // R11
  out_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out_en |-> (state == ST_SHF_IR || state == ST_SHF_DR));

endmodule

bind tap_access_port tap_access_chk #(.NPINS(NPINS)) u_chk (
  .clk(test_clk), .rst_n(test_rst_n), .mode_sel(mode_sel), .state(st),
  .ir_sr(ir_sr), .ir_q(ir_q), .pin_oe(pin_oe), .ser_out_en(ser_out_en)
);

// File: tb/tap_access_port_bench.sv
`timescale 1ns/1ps
module tap_access_port_bench;

  localparam int N = 4;
  localparam logic [31:0] IDV = 32'h1A5C_E0B3;
  localparam logic [31:0] USV = 32'h0C0F_FEE5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_sel = 1'b1;
  logic         ser_in = 1'b0;
  logic         ser_out, ser_out_en;
  logic [N-1:0] core_out = 4'b1010;
  logic [N-1:0] core_oe  = 4'b1111;
  logic [N-1:0] pin_in   = 4'b0011;
  logic [N-1:0] core_in, pin_out, pin_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  tap_access_port #(.NPINS(N), .IDENT_VAL(IDV), .USER_VAL(USV)) u_tap_access_port (
    .test_clk(clk), .test_rst_n(rst_n), .mode_sel(mode_sel), .ser_in(ser_in),
    .ser_out(ser_out), .ser_out_en(ser_out_en), .core_out(core_out),
    .core_oe(core_oe), .core_in(core_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic t);
    @(negedge clk); #1 mode_sel = t;
    @(posedge clk); #1;
  endtask

  task automatic shift_bits(input int n, input logic [63:0] din, input bit last_hi,
                            output logic [63:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      dout[i]  = ser_out;
      if (i == 0) chk("R11 out enable in shift", 64'(ser_out_en), 64'd1);
      mode_sel = last_hi && (i == n - 1);
      ser_in   = din[i];
      @(posedge clk); #1;
    end
  endtask

  // leaves the controller in Exit1-IR
  task automatic ir_shift(input logic [3:0] op, output logic [63:0] cap);
    step(1); step(1); step(0); step(0);
    shift_bits(4, 64'(op), 1, cap);
  endtask

  task automatic load_ir(input logic [3:0] op);
    logic [63:0] cap;
    ir_shift(op, cap);
    step(1); step(0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    step(1); step(0); step(0);
    shift_bits(n, din, 1, dout);
    step(1); step(0);
  endtask

  function automatic logic [63:0] delayed(input logic [63:0] d, input int n);
    logic [63:0] r = '0;
    for (int i = 1; i < n; i++) r[i] = d[i-1];
    return r;
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    #35;
    chk("R12 out enable at reset", 64'(ser_out_en), 64'd0);
    chk("R12 pins follow core", 64'({pin_oe, pin_out}), 64'({core_oe, core_out}));
    chk("R12 core input from pins", 64'(core_in), 64'(pin_in));
    @(negedge clk); #2 rst_n = 1'b1;
    step(0);
  endtask

  task automatic t_ident;
    logic [63:0] d;
    scan_dr(32, 64'h0, d);
    chk("R4 identification after reset", d, 64'(IDV));
    chk("R4 ident lsb", 64'(d[0]), 64'd1);
  endtask

  task automatic t_ir_capture;
    logic [63:0] c;
    ir_shift(4'b0011, c);
    chk("R2 ir capture pattern", c, 64'h5);
    step(1); step(0);
  endtask

  task automatic t_user;
    logic [63:0] d;
    scan_dr(32, 64'h0, d);
    chk("R5 user code", d, 64'(USV));
  endtask

  task automatic t_five_high;
    logic [63:0] d;
    step(1); step(0); step(0);
    repeat (5) step(1);
    step(0);
    scan_dr(32, 64'h0, d);
    chk("R1 five highs restore ident", d, 64'(IDV));
  endtask

  task automatic t_pass(input logic [3:0] op, input string req);
    logic [63:0] d;
    logic [63:0] pat = 64'hB6;
    load_ir(op);
    scan_dr(8, pat, d);
    chk(req, d, delayed(pat, 8));
  endtask

  task automatic t_snap;
    logic [63:0] d;
    load_ir(4'b0001);
    scan_dr(12, 64'hC69, d);
    chk("R6 snapshot capture", d, 64'hFA3);
    chk("R6 pins stay core", 64'({pin_oe, pin_out}), 64'({core_oe, core_out}));
    chk("R6 core input from pins", 64'(core_in), 64'(pin_in));
  endtask

  task automatic t_ext;
    logic [63:0] c;
    ir_shift(4'b0000, c);
    chk("R2 no effect before update", 64'({pin_oe, pin_out}), 64'({core_oe, core_out}));
    step(1); step(0);
    chk("R7 pins from latches", 64'({pin_oe, pin_out}), 64'({4'b1100, 4'b0110}));
    core_out = 4'b0101;
    #1 chk("R7 pins ignore core", 64'(pin_out), 64'(4'b0110));
    core_out = 4'b1010;
  endtask

  task automatic t_int;
    logic [63:0] d;
    load_ir(4'b0110);
    chk("R10 core input from latches", 64'(core_in), 64'(4'b1001));
    scan_dr(12, 64'h5A6, d);
    chk("R10 boundary on path", d, 64'hFA3);
    chk("R10 core input updated", 64'(core_in), 64'(4'b0110));
    chk("R10 pins from latches", 64'({pin_oe, pin_out}), 64'({4'b0101, 4'b1010}));
  endtask

  task automatic t_hold;
    logic [63:0] d;
    logic [63:0] pat = 64'h3C;
    load_ir(4'b0100);
    chk("R8 pins from latches", 64'({pin_oe, pin_out}), 64'({4'b0101, 4'b1010}));
    scan_dr(8, pat, d);
    chk("R8 one-bit path", d, delayed(pat, 8));
    chk("R8 latches unchanged", 64'({pin_oe, pin_out}), 64'({4'b0101, 4'b1010}));
    chk("R8 core input from pins", 64'(core_in), 64'(pin_in));
  endtask

  task automatic t_float;
    logic [63:0] d;
    logic [63:0] pat = 64'h9D;
    load_ir(4'b0111);
    chk("R9 all outputs floated", 64'(pin_oe), 64'd0);
    scan_dr(8, pat, d);
    chk("R9 one-bit path", d, delayed(pat, 8));
    chk("R11 out enable idle", 64'(ser_out_en), 64'd0);
  endtask

  initial begin
    t_reset();
    t_ident();
    t_ir_capture();
    t_user();
    t_five_high();
    t_pass(4'b1111, "R3 all-ones pass-through");
    t_pass(4'b1010, "R3 unassigned pass-through");
    t_snap();
    t_ext();
    t_int();
    t_hold();
    t_float();
    t_reset();
    t_ident();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule